// File: doc/BRIEF.md
# Serial Synthesizer Tuning Register Loader

This block is a write-only serial slave for a direct digital synthesizer. A host sends 16-bit command words, most significant bit first, each one framed by an active-low select line. Once a frame closes, the block looks at the top bits of the word to choose a register. It then loads one of five registers: a 14-bit control register, two 28-bit frequency tuning registers or two 12-bit phase offset registers. All five are driven continuously as parallel outputs to the synthesis core.

A 28-bit tuning value is wider than one word can carry. When the control register selects full-width loading, the host sends a low 14-bit half and then a high 14-bit half, each in its own frame. The low half waits in a staging register. The target register takes the whole 28-bit value in a single cycle, and only when the matching high half arrives, so the synthesizer never runs on a half-updated tuning word. When full-width loading is off, each frequency word replaces one 14-bit half of its target, and a control bit chooses which half.

The serial lines are sampled in the block's own clock domain. The serial clock must therefore toggle slower than half the system clock rate.

Top module: `dds_regif_top`

## Requirements
- R1: While reset is asserted and right after it is released, the control, both frequency and both phase outputs are zero, and the staging logic expects a low half.
- R2: A 16-bit frame whose bits 15:14 are 00 loads bits 13:0 into the control output. Bit 13 of the control register is full-width mode and bit 12 is half select.
- R3: A frame whose bits 15:14 are 11 loads bits 11:0 into phase register 1 when bit 13 is set, or into phase register 0 when bit 13 is clear. Bit 12 is ignored, and the other phase register keeps its value.
- R4: In full-width mode, a frame with prefix 01 (frequency register 0) or 10 (frequency register 1) first stages its 14 payload bits as the low half and leaves the outputs unchanged. The next frame with the same prefix supplies bits 27:14, and both halves then update the target register in the same cycle.
- R5: In full-width mode, if a low half for one frequency register is staged and the next frequency frame addresses the other register, the staged half is dropped. The new word becomes the staged low half of the other register, and no frequency output changes.
- R6: With full-width mode clear, a frequency frame replaces bits 27:14 of its target when half select is set, or bits 13:0 when it is clear. The other half keeps its value.
- R7: A frame that ends after any bit count other than 16 changes no register and does not disturb the staging state.
- R8: A frequency write made with full-width mode clear empties the staging register. The next full-width frequency frame is then taken as a low half.
- R9: Words are shifted in most significant bit first, one bit per rising serial clock edge while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_csn_i | input | 1 | Active-low frame select |
| ser_sck_i | input | 1 | Serial clock, data taken on its rising edge |
| ser_sdi_i | input | 1 | Serial data in, MSB first |
| ctrl_o | output | 14 | Control register contents |
| freq0_o | output | 28 | Frequency tuning register 0 |
| freq1_o | output | 28 | Frequency tuning register 1 |
| phase0_o | output | 12 | Phase offset register 0 |
| phase1_o | output | 12 | Phase offset register 1 |

## Verification
Directed sequences cover several cases. Half-mode writes to each half show which half the half-select bit picks. A full-width low/high pair shows that nothing is visible until the pair completes. A low half followed by a word for the other register shows that staging follows its target. A half-mode write placed between full-width words shows that staging is flushed. Frames of 15 and 17 bits, which look like valid control writes, show that only exact 16-bit frames are accepted. Asymmetric data patterns expose any bit reversal. A seeded random stream of all prefixes, with occasional short frames mixed in, is compared word by word against a reference model in the bench.

// File: rtl/dds_regif_pkg.sv
package dds_regif_pkg;

  typedef enum logic [2:0] {
    TGT_CTRL   = 3'd0,
    TGT_FREQ0  = 3'd1,
    TGT_FREQ1  = 3'd2,
    TGT_PHASE0 = 3'd3,
    TGT_PHASE1 = 3'd4
  } tgt_e;

endpackage

// File: rtl/dds_shift_rx.sv
// Serial shift-in and framing. Inputs are sampled in the clk domain;
// a word is released only when select rises after exactly WORD_W bits.
module dds_shift_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

  logic              csn_q, csn_q2, sck_q, sck_q2, sdi_q;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              vld_q, vld_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              sck_rise, frame_end, sh_en;

  always_comb begin
    sck_rise  = sck_q & ~sck_q2;
    frame_end = csn_q & ~csn_q2;
    sh_en     = ~csn_q & sck_rise;
    sh_n      = sh_q;
    cnt_n     = cnt_q;
    vld_n     = 1'b0;
    word_n    = word_q;
    if (sh_en) begin
      sh_n = {sh_q[WORD_W-2:0], sdi_q};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
    if (frame_end) begin
      cnt_n = '0;
      if (cnt_q == CNT_WORD) begin
        vld_n  = 1'b1;
        word_n = sh_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= 1'b1;
      csn_q2 <= 1'b1;
      sck_q  <= 1'b0;
      sck_q2 <= 1'b0;
      sdi_q  <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      csn_q  <= csn_i;
      csn_q2 <= csn_q;
      sck_q  <= sck_i;
      sck_q2 <= sck_q;
      sdi_q  <= sdi_i;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      vld_q  <= vld_n;
      word_q <= word_n;
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;
endmodule

// File: rtl/dds_addr_decode.sv
// Variable-length prefix decode: two bits, plus a third for phase targets.
module dds_addr_decode
  import dds_regif_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output tgt_e              tgt_o
);
  always_comb begin
    unique case (word_i[WORD_W-1 -: 2])
      2'b00:   tgt_o = TGT_CTRL;
      2'b01:   tgt_o = TGT_FREQ0;
      2'b10:   tgt_o = TGT_FREQ1;
      default: tgt_o = word_i[WORD_W-3] ? TGT_PHASE1 : TGT_PHASE0;
    endcase
  end
endmodule

// File: rtl/dds_freq_assembler.sv
// Frequency registers with half-word staging and single-cycle commit.
module dds_freq_assembler #(
  parameter int FREQ_W = 28,
  parameter int NREG   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_vld_i,
  input  logic [$clog2(NREG)-1:0]     wr_sel_i,
  input  logic [FREQ_W/2-1:0]         wr_data_i,
  input  logic                        full_mode_i,
  input  logic                        hi_half_i,
  output logic [NREG-1:0][FREQ_W-1:0] freq_o
);
  localparam int HALF_W = FREQ_W / 2;
  localparam int SEL_W  = $clog2(NREG);

  logic              stg_full_q, stg_full_n;
  logic [SEL_W-1:0]  stg_sel_q, stg_sel_n;
  logic [HALF_W-1:0] stg_dat_q, stg_dat_n;
  logic              pair_hit;

  always_comb begin
    pair_hit   = stg_full_q && (stg_sel_q == wr_sel_i);
    stg_full_n = stg_full_q;
    stg_sel_n  = stg_sel_q;
    stg_dat_n  = stg_dat_q;
    if (wr_vld_i) begin
      if (!full_mode_i) begin
        stg_full_n = 1'b0;
      end else if (pair_hit) begin
        stg_full_n = 1'b0;
      end else begin
        stg_full_n = 1'b1;
        stg_sel_n  = wr_sel_i;
        stg_dat_n  = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_full_q <= 1'b0;
      stg_sel_q  <= '0;
      stg_dat_q  <= '0;
    end else begin
      stg_full_q <= stg_full_n;
      stg_sel_q  <= stg_sel_n;
      stg_dat_q  <= stg_dat_n;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_freq
    logic              en;
    logic [FREQ_W-1:0] nxt;
    logic [FREQ_W-1:0] q;

    always_comb begin
      en  = wr_vld_i && (wr_sel_i == SEL_W'(k)) && (!full_mode_i || pair_hit);
      if (full_mode_i)    nxt = {wr_data_i, stg_dat_q};
      else if (hi_half_i) nxt = {wr_data_i, q[HALF_W-1:0]};
      else                nxt = {q[FREQ_W-1:HALF_W], wr_data_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign freq_o[k] = q;
  end
endmodule

// File: rtl/dds_regif_top.sv
module dds_regif_top
  import dds_regif_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_csn_i,
  input  logic               ser_sck_i,
  input  logic               ser_sdi_i,
  output logic [WORD_W-3:0]  ctrl_o,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o
);
  localparam int CTRL_W   = WORD_W - 2;
  localparam int HALF_W   = FREQ_W / 2;
  localparam int BIT_FULL = CTRL_W - 1;
  localparam int BIT_HALF = CTRL_W - 2;

  logic              word_vld;
  logic [WORD_W-1:0] word;
  tgt_e              tgt;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PHASE_W-1:0] ph0_q, ph1_q;
  logic              ctrl_en, ph0_en, ph1_en, fq_vld;
  logic [1:0][FREQ_W-1:0] fq;

  dds_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .csn_i(ser_csn_i), .sck_i(ser_sck_i), .sdi_i(ser_sdi_i),
    .word_vld_o(word_vld), .word_o(word)
  );

  dds_addr_decode #(.WORD_W(WORD_W)) u_dec (
    .word_i(word), .tgt_o(tgt)
  );

  always_comb begin
    ctrl_en = word_vld && (tgt == TGT_CTRL);
    ph0_en  = word_vld && (tgt == TGT_PHASE0);
    ph1_en  = word_vld && (tgt == TGT_PHASE1);
    fq_vld  = word_vld && ((tgt == TGT_FREQ0) || (tgt == TGT_FREQ1));
  end

  dds_freq_assembler #(.FREQ_W(FREQ_W), .NREG(2)) u_fq (
    .clk(clk), .rst_n(rst_n),
    .wr_vld_i(fq_vld),
    .wr_sel_i(tgt == TGT_FREQ1),
    .wr_data_i(word[HALF_W-1:0]),
    .full_mode_i(ctrl_q[BIT_FULL]),
    .hi_half_i(ctrl_q[BIT_HALF]),
    .freq_o(fq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ph0_q  <= '0;
      ph1_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= word[CTRL_W-1:0];
      if (ph0_en)  ph0_q  <= word[PHASE_W-1:0];
      if (ph1_en)  ph1_q  <= word[PHASE_W-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign freq0_o  = fq[0];
  assign freq1_o  = fq[1];
  assign phase0_o = ph0_q;
  assign phase1_o = ph1_q;
endmodule

// File: rtl/dds_regif_chk.sv
module dds_regif_chk #(
  parameter int CTRL_W  = 14,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               word_vld,
  input logic [CTRL_W-1:0]  ctrl,
  input logic [FREQ_W-1:0]  freq0,
  input logic [FREQ_W-1:0]  freq1,
  input logic [PHASE_W-1:0] ph0,
  input logic [PHASE_W-1:0] ph1
);
  localparam int HALF_W = FREQ_W / 2;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (ctrl == '0 && freq0 == '0 && freq1 == '0 && ph0 == '0 && ph1 == '0));

  assert_ctrl_on_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(word_vld));

  assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(ph0) && !$stable(ph1)));

  assert_freq_on_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(freq0) || !$stable(freq1)) |-> $past(word_vld));

  assert_one_freq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(freq0) && !$stable(freq1)));

  assert_half_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl[CTRL_W-1]) |->
      (freq0[FREQ_W-1:HALF_W] == $past(freq0[FREQ_W-1:HALF_W]) ||
       freq0[HALF_W-1:0] == $past(freq0[HALF_W-1:0])));
endmodule

bind dds_regif_top dds_regif_chk #(
  .CTRL_W(WORD_W - 2), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .ctrl(ctrl_o),
  .freq0(freq0_o), .freq1(freq1_o), .ph0(phase0_o), .ph1(phase1_o)
);

// File: tb/sim_dds_regif_top.sv
module sim_dds_regif_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csn, sck, sdi;
  logic [13:0] ctrl_o;
  logic [27:0] freq0_o, freq1_o;
  logic [11:0] phase0_o, phase1_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [13:0] e_ctrl;
  logic [27:0] e_freq [2];
  logic [11:0] e_ph0, e_ph1;
  bit          s_full;
  int          s_sel;
  logic [13:0] s_dat;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_regif_top u0 (
    .clk(clk), .rst_n(rst_n),
    .ser_csn_i(csn), .ser_sck_i(sck), .ser_sdi_i(sdi),
    .ctrl_o(ctrl_o), .freq0_o(freq0_o), .freq1_o(freq1_o),
    .phase0_o(phase0_o), .phase1_o(phase1_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "ctrl",   28'(ctrl_o),   28'(e_ctrl));
    chk(req, "freq0",  freq0_o,       e_freq[0]);
    chk(req, "freq1",  freq1_o,       e_freq[1]);
    chk(req, "phase0", 28'(phase0_o), 28'(e_ph0));
    chk(req, "phase1", 28'(phase1_o), 28'(e_ph1));
  endtask

  // Reference model of a committed 16-bit word, from the requirements.
  task automatic model(input logic [15:0] w);
    int k;
    case (w[15:14])
      2'b00: e_ctrl = w[13:0];
      2'b11: if (w[13]) e_ph1 = w[11:0]; else e_ph0 = w[11:0];
      default: begin
        k = (w[15:14] == 2'b10) ? 1 : 0;
        if (e_ctrl[13]) begin
          if (s_full && s_sel == k) begin
            e_freq[k] = {w[13:0], s_dat};
            s_full = 0;
          end else begin
            s_full = 1; s_sel = k; s_dat = w[13:0];
          end
        end else begin
          s_full = 0;
          if (e_ctrl[12]) e_freq[k][27:14] = w[13:0];
          else            e_freq[k][13:0]  = w[13:0];
        end
      end
    endcase
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      sck = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = 1'b0;
    repeat (2) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    frame(32'(w), 16);
    model(w);
  endtask

  initial begin
    rst_n = 1'b1; csn = 1'b1; sck = 1'b0; sdi = 1'b0;
    e_ctrl = '0; e_freq[0] = '0; e_freq[1] = '0; e_ph0 = '0; e_ph1 = '0;
    s_full = 0; s_sel = 0; s_dat = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 after reset");

    // R2 control load with asymmetric pattern (also R9 bit order)
    send(16'h0A53); chk_all("R2 ctrl load");
    chk("R9", "ctrl msb-first", 28'(ctrl_o), 28'h0A53);
    send(16'h0000); chk_all("R2 ctrl clear");

    // R6 half mode, low then high half
    send(16'h4000 | 16'h1234); chk("R6", "freq0 low", freq0_o, 28'h0001234);
    send(16'h1000);            // half select = upper
    send(16'h4000 | 16'h0ABC); chk("R6", "freq0 high", freq0_o, 28'h2AF1234);
    chk_all("R6");

    // R3 phase registers, bit 12 ignored
    send(16'hC123); chk("R3", "phase0", 28'(phase0_o), 28'h123);
    send(16'hFFFF); chk("R3", "phase1 bit12 ignored", 28'(phase1_o), 28'hFFF);
    chk("R3", "phase0 kept", 28'(phase0_o), 28'h123);

    // R4 full-width pair
    send(16'h2000);
    send(16'h8000 | 16'h0111); chk("R4", "freq1 held after low", freq1_o, 28'h0);
    send(16'h8000 | 16'h2222); chk("R4", "freq1 committed", freq1_o, 28'h8888111);
    chk_all("R4");

    // R5 staging switches target
    send(16'h4000 | 16'h0005);
    send(16'h8000 | 16'h0006); chk_all("R5 no change");
    send(16'h8000 | 16'h0007); chk("R5", "freq1 new pair", freq1_o, 28'h001C006);
    chk("R5", "freq0 kept", freq0_o, 28'h2AF1234);

    // R7 wrong-length frames, including one mid-pair
    send(16'h4000 | 16'h0011);
    frame(32'h0000_0000, 15); chk_all("R7 15-bit frame");
    frame(32'h0000_0000, 17); chk_all("R7 17-bit frame");
    send(16'h4000 | 16'h0022); chk("R7", "pair intact", freq0_o, 28'h0088011);

    // R8 half-mode write flushes staging
    send(16'h4000 | 16'h0033);  // staged low
    send(16'h0000);             // half mode, lower
    send(16'h4000 | 16'h0044); chk("R8", "half write", freq0_o, 28'h0088044);
    send(16'h2000);
    send(16'h4000 | 16'h0055); chk("R8", "taken as low", freq0_o, 28'h0088044);
    send(16'h4000 | 16'h0066); chk("R8", "pair", freq0_o, 28'h0198055);
    chk_all("R8");

    // Seeded random stream
    void'($urandom(32'd20240611));
    for (int i = 0; i < 250; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 16) == 0) begin
        frame(32'($urandom), (($urandom % 2) == 0) ? 15 : 17);
        chk_all("R7 random short/long");
      end else begin
        send(w);
        chk_all("R2 R3 R4 R6 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule